// File: doc/BRIEF.md
# Fractional Sample Rate Tick Generator

This block produces a periodic one-cycle sample strobe from the master clock. A 12-bit rate word SR is added into a 19-bit phase accumulator on every clock while the generator runs. Each carry out of the accumulator is one sample tick, so the mean tick rate is Fclk·SR/2^19. The rate word is written as two byte-wide registers: a low byte and a 4-bit high part.

A host reaches the block through a small register port with write strobe, address, write data and combinational read data. The run bit is resynchronized before it starts the accumulator, and clearing it stops and zeroes the accumulator at once. Every overflow sets a sticky interrupt flag. The flag drives the interrupt output through a separate enable bit, and it can be cleared in four ways: master chip reset, run cleared, a status-register write with bit 5 set, or any write to the control register. The rate registers are never reset.

Top module: `srate_tick_gen`

## Requirements
- R1: Address 0 holds rate bits 7:0 and address 1 holds rate bits 11:8 in its data bits 3:0. Reading address 1 returns zeros in bits 7:4, and writing 0xFF there reads back as 0x0F.
- R2: While running, the number of ticks over the first M accumulating cycles is floor(M·SR/524288). Each tick lasts one cycle.
- R3: Writing 0 to the run bit (address 2, bit 0) stops ticks and zeroes the accumulator. A later restart gives the same first-tick timing as a fresh start.
- R4: A write that sets the run bit takes effect at clock edge E0. Accumulation starts one cycle later. The first tick is visible after edge E0 + 1 + ceil(524288/SR). With SR = 0 no tick ever occurs.
- R5: Each overflow sets the interrupt flag. The flag reads back at address 2 bit 1, beside the run bit at bit 0.
- R6: The flag is cleared by master chip reset, by the run bit being 0, by a status write with bit 5 = 1, or by any write to address 2. A status write with bit 5 = 0 leaves the flag set. A clear wins over an overflow in the same cycle.
- R7: irq_o is high exactly when the flag and the enable bit (address 3, bit 0) are both set. Readback of the flag is not masked by the enable.
- R8: Hardware reset and master chip reset each clear the run bit, the enable bit, the flag and the tick. Master chip reset leaves both rate registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Hardware reset, synchronous, active high |
| chip_rst | input | 1 | Master chip reset, synchronous, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| stat_wr | input | 1 | Status-register write strobe |
| stat_wdata | input | 8 | Status write data; bit 5 clears the flag |
| tick_o | output | 1 | One-cycle sample tick |
| irq_o | output | 1 | Flag gated by the interrupt enable |

## Verification
The checker watches several rules on every cycle. Ticks only follow an active cycle and are never back to back. While the run bit is zero the flag stays low. Any clear request leaves the flag low on the next cycle, and an uncleared tick always sets it. Only the bench scenarios show the exact tick counts and first-tick latency for several rate words, register readback widths, the rate registers surviving chip reset, and the effect of each clear path and of the enable at the ports.

// File: rtl/srt_pkg.sv
package srt_pkg;
  typedef enum logic [1:0] {
    A_RATE_LO = 2'd0,
    A_RATE_HI = 2'd1,
    A_CTRL    = 2'd2,
    A_IEN     = 2'd3
  } srt_addr_e;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_FLAG_BIT = 1;
  localparam int IEN_BIT       = 0;
  localparam int STAT_CLR_BIT  = 5;
endpackage

// File: rtl/srt_regs.sv
module srt_regs
  import srt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RATE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_rst,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              flag_i,
  output logic [RATE_W-1:0] rate_o,
  output logic              run_o,
  output logic              ien_o,
  output logic              ctrl_wr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int LO_W = DATA_W;
  localparam int HI_W = RATE_W - DATA_W;

  logic [LO_W-1:0] rate_lo;
  logic [HI_W-1:0] rate_hi;
  logic            run_q;
  logic            ien_q;

  wire wr_lo   = wr && (addr == A_RATE_LO);
  wire wr_hi   = wr && (addr == A_RATE_HI);
  wire wr_ctrl = wr && (addr == A_CTRL);
  wire wr_ien  = wr && (addr == A_IEN);

  // rate registers are deliberately left without reset
  always_ff @(posedge clk) begin
    if (wr_lo) rate_lo <= wdata[LO_W-1:0];
    if (wr_hi) rate_hi <= wdata[HI_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || chip_rst) begin
      run_q <= 1'b0;
      ien_q <= 1'b0;
    end else begin
      if (wr_ctrl) run_q <= wdata[CTRL_RUN_BIT];
      if (wr_ien)  ien_q <= wdata[IEN_BIT];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr)
      A_RATE_LO: rdata_o[LO_W-1:0] = rate_lo;
      A_RATE_HI: rdata_o[HI_W-1:0] = rate_hi;
      A_CTRL: begin
        rdata_o[CTRL_RUN_BIT]  = run_q;
        rdata_o[CTRL_FLAG_BIT] = flag_i;
      end
      default:   rdata_o[IEN_BIT] = ien_q;
    endcase
  end

  assign rate_o    = {rate_hi, rate_lo};
  assign run_o     = run_q;
  assign ien_o     = ien_q;
  assign ctrl_wr_o = wr_ctrl;
endmodule

// File: rtl/srt_phase_acc.sv
module srt_phase_acc #(
  parameter int RATE_W = 12,
  parameter int ACC_W  = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_rst,
  input  logic              run_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              run_act_o,
  output logic              ovf_o,
  output logic              tick_o,
  output logic [ACC_W-1:0]  acc_o
);
  logic             run_sync;
  logic [ACC_W-1:0] acc_q;
  logic             tick_q;
  logic [ACC_W:0]   step;

  // one accumulation step: {carry, sum}
  function automatic logic [ACC_W:0] phase_step(input logic [ACC_W-1:0] a,
                                                input logic [RATE_W-1:0] r);
    phase_step = {1'b0, a} + {{(ACC_W+1-RATE_W){1'b0}}, r};
  endfunction

  always_ff @(posedge clk) begin
    if (rst || chip_rst) run_sync <= 1'b0;
    else                 run_sync <= run_i;
  end

  // start waits for the synced copy, stop acts at once
  assign run_act_o = run_i && run_sync;
  assign step      = phase_step(acc_q, rate_i);
  assign ovf_o     = run_act_o && step[ACC_W];

  always_ff @(posedge clk) begin
    if (rst || chip_rst || !run_act_o) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= step[ACC_W-1:0];
      tick_q <= step[ACC_W];
    end
  end

  assign tick_o = tick_q;
  assign acc_o  = acc_q;
endmodule

// File: rtl/srt_irq_flag.sv
module srt_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic chip_rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic ien_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst || chip_rst || clr_i) flag_q <= 1'b0;
    else if (set_i)               flag_q <= 1'b1;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q && ien_i;
endmodule

// File: rtl/srate_tick_gen.sv
module srate_tick_gen
  import srt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RATE_W = 12,
  parameter int ACC_W  = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              stat_wr,
  input  logic [DATA_W-1:0] stat_wdata,
  output logic              tick_o,
  output logic              irq_o
);
  logic [RATE_W-1:0] rate;
  logic              run_q;
  logic              ien;
  logic              ctrl_wr;
  logic              irq_flag;
  logic              run_act;
  logic              ovf_evt;
  logic [ACC_W-1:0]  acc;
  logic              flag_clr;

  srt_regs #(.DATA_W(DATA_W), .RATE_W(RATE_W)) u_regs (
    .clk(clk), .rst(rst), .chip_rst(chip_rst),
    .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .flag_i(irq_flag), .rate_o(rate), .run_o(run_q), .ien_o(ien),
    .ctrl_wr_o(ctrl_wr), .rdata_o(reg_rdata)
  );

  srt_phase_acc #(.RATE_W(RATE_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .chip_rst(chip_rst),
    .run_i(run_q), .rate_i(rate),
    .run_act_o(run_act), .ovf_o(ovf_evt), .tick_o(tick_o), .acc_o(acc)
  );

  assign flag_clr = ctrl_wr || !run_q || (stat_wr && stat_wdata[STAT_CLR_BIT]);

  srt_irq_flag u_flag (
    .clk(clk), .rst(rst), .chip_rst(chip_rst),
    .set_i(ovf_evt), .clr_i(flag_clr), .ien_i(ien),
    .flag_o(irq_flag), .irq_o(irq_o)
  );
endmodule

// File: rtl/srt_checker.sv
module srt_checker #(
  parameter int ACC_W = 19
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_o,
  input logic             run_q,
  input logic             run_act,
  input logic             irq_flag,
  input logic             flag_clr,
  input logic [ACC_W-1:0] acc
);
  AST_TICK_AFTER_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> $past(run_act)); // R3

  AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o); // R2

  AST_STOP_ZEROES_ACC: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> (acc == '0)); // R3

  AST_TICK_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (tick_o && !$past(flag_clr)) |-> irq_flag); // R5

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    $past(flag_clr) |-> !irq_flag); // R6

  AST_IDLE_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    !run_q |-> !irq_flag); // R6
endmodule

bind srate_tick_gen srt_checker #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .tick_o(tick_o), .run_q(run_q), .run_act(run_act),
  .irq_flag(irq_flag), .flag_clr(flag_clr), .acc(acc)
);

// File: tb/tb_srate_tick_gen.sv
module tb_srate_tick_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       chip_rst = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       stat_wr = 1'b0;
  logic [7:0] stat_wdata = 8'd0;
  logic       tick_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  srate_tick_gen dut (
    .clk(clk), .rst(rst), .chip_rst(chip_rst),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .tick_o(tick_o), .irq_o(irq_o)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic stat(input logic [7:0] d);
    @(negedge clk);
    stat_wr = 1'b1; stat_wdata = d;
    @(negedge clk);
    stat_wr = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [1:0] a, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic set_rate(input int sr);
    wr(2'd0, sr[7:0]);
    wr(2'd1, {4'd0, sr[11:8]});
  endtask

  function automatic longint exp_ticks(input longint m, input longint sr);
    return (m * sr) / 524288;
  endfunction

  function automatic longint exp_first(input longint sr);
    if (sr == 0) return -1;
    return (524288 + sr - 1) / sr;
  endfunction

  // start from stopped, count ticks over m accumulating cycles
  task automatic run_window(input string tag, input int sr, input int m);
    int cnt = 0;
    int first = -1;
    wr(2'd2, 8'h01);
    @(negedge clk);
    check({tag, " no tick in sync cycle"}, tick_o, 0);
    for (int n = 1; n <= m; n++) begin
      @(negedge clk);
      if (tick_o) begin
        cnt++;
        if (first < 0) first = n;
      end
    end
    check({tag, " tick count"}, cnt, exp_ticks(m, sr));
    check({tag, " first tick"}, first, exp_first(sr));
  endtask

  task automatic wait_tick();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (tick_o) break;
    end
  endtask

  task automatic t_reset();
    check("R8 tick after reset", tick_o, 0);
    check("R8 irq after reset", irq_o, 0);
    rd_check("R8 ctrl after reset", 2'd2, 8'h00);
    rd_check("R8 enable after reset", 2'd3, 8'h00);
  endtask

  task automatic t_rate_regs();
    wr(2'd1, 8'hFF);
    rd_check("R1 high part width", 2'd1, 8'h0F);
    set_rate(12'h800);
    rd_check("R1 low byte", 2'd0, 8'h00);
    rd_check("R1 high part", 2'd1, 8'h08);
  endtask

  task automatic t_flag_and_enable();
    run_window("R2 R4 SR=0x800", 12'h800, 1024);
    rd_check("R5 flag and run readback", 2'd2, 8'h03);
    check("R7 irq masked by enable", irq_o, 0);
    wr(2'd3, 8'h01);
    #1 check("R7 irq with enable", irq_o, 1);
    rd_check("R7 flag readback unmasked", 2'd2, 8'h03);
    stat(8'hDF);
    rd_check("R6 status bit5=0 keeps flag", 2'd2, 8'h03);
    stat(8'h20);
    rd_check("R6 status bit5 clears flag", 2'd2, 8'h01);
    check("R6 irq low after clear", irq_o, 0);
    wait_tick();
    #1 check("R5 tick sets flag, irq", irq_o, 1);
    wr(2'd2, 8'h01);
    rd_check("R6 ctrl write clears flag", 2'd2, 8'h01);
  endtask

  task automatic t_stop_restart();
    int cnt = 0;
    wr(2'd2, 8'h00);
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (tick_o) cnt++;
    end
    check("R3 no ticks when stopped", cnt, 0);
    rd_check("R3 ctrl when stopped", 2'd2, 8'h00);
    run_window("R3 restart", 12'h800, 300);
  endtask

  task automatic t_chip_reset();
    @(negedge clk);
    chip_rst = 1'b1;
    @(negedge clk);
    chip_rst = 1'b0;
    check("R8 tick after chip reset", tick_o, 0);
    rd_check("R8 ctrl after chip reset", 2'd2, 8'h00);
    rd_check("R8 enable after chip reset", 2'd3, 8'h00);
    rd_check("R8 low rate kept", 2'd0, 8'h00);
    rd_check("R8 high rate kept", 2'd1, 8'h08);
  endtask

  task automatic t_other_rates();
    set_rate(12'hFFF);
    run_window("R2 SR=0xFFF", 12'hFFF, 1000);
    rd_check("R5 flag set at max rate", 2'd2, 8'h03);
    wr(2'd2, 8'h00);
    rd_check("R6 run=0 clears flag", 2'd2, 8'h00);
    set_rate(12'h000);
    run_window("R4 SR=0", 0, 500);
    rd_check("R4 no flag with SR=0", 2'd2, 8'h01);
    wr(2'd2, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_rate_regs();
    t_flag_and_enable();
    t_stop_restart();
    t_chip_reset();
    t_other_rates();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule